// File: doc/BRIEF.md
# Command and Response Transfer Engine

This block is the byte-stream engine that sits behind the status register and the data port of a security-module register interface. A bus master places a command into the data port one to four bytes at a time. The engine learns how long the command is from a big-endian length field in the command header. When the command is complete, the master issues a go request and the engine hands the command to an execution backend through a start/done handshake. The backend leaves its response in the same byte store. The master then drains the response through the data port and may rewind it and read it again.

Progress is tracked by a five-state protocol: idle, ready, receiving, executing and complete. It is visible through the flag byte of the status register, together with a burst count in bits 23:8 and a constant family code in bits 27:26. Every internal status update replaces the flag byte but keeps the self-test flag. Locality arbitration and interrupt routing are outside this block. The command-ready and response-ready events are brought out as single-cycle pulses for a neighbouring block to use.

Top module: `cmdfifo_engine`

## Requirements
- R1: After reset the engine is idle. A 32-bit status read returns only the family code in bits 27:26 and the burst count, which is the full buffer depth, in bits 23:8. Flag bits: valid=7, commandReady=6, go=5, dataAvail=4, expect=3, selftestDone=2, responseRetry=1; cancel is bit 24.
- R2: Writing a status value whose command bits (6, 5, 1) equal exactly commandReady while idle moves the engine to ready, leaves only commandReady (plus self-test) set, and pulses `evt_cmd_ready`.
- R3: Data-port writes while idle, executing or complete store nothing; the burst count and the flags are unchanged.
- R4: The first data-port write while ready enters receiving with expect and valid set, and stores its bytes from byte 0 upward.
- R5: Once more than 5 bytes are stored, bytes 2..5 form a big-endian length. Expect stays set while that length exceeds the stored byte count and is cleared, leaving valid, when it does not.
- R6: Go (bit 5 alone) starts execution only while receiving with expect clear. It pulses `be_start` with `be_cmd_len` equal to the stored byte count. In every other case it has no effect.
- R7: Backend completion enters complete with valid and dataAvail set and pulses `evt_rsp_ready`; a self-test indication sets bit 2, which survives until reset. Data reads return the response bytes in order, and reading the last byte (by the length in response bytes 2..5) leaves only valid set.
- R8: A data-port read byte returns 0xFF when dataAvail is clear or the engine is not complete.
- R9: The burst count is the number of remaining response bytes while dataAvail is set, and the free write space otherwise. A byte-wide status read saturates it at 0xFF.
- R10: responseRetry alone while complete rewinds the response to byte 0 and sets valid and dataAvail again.
- R11: A data-port access of size S at byte offset O transfers min(S, 4-O) bytes, packed little-endian from bit 0 of the data word.
- R12: commandReady while complete returns to ready, clears dataAvail, resets both offsets, sets commandReady and pulses `evt_cmd_ready`.
- R13: commandReady while receiving aborts at once: the engine goes to ready with commandReady set and pulses `evt_cmd_ready`. While executing, the engine pulses `be_cancel` (as does a write of bit 24) and, on backend completion, goes to ready with commandReady set instead of complete.
- R14: When the write store is full, further bytes are dropped and the flags become valid only, with a burst count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = status register, 1 = data port |
| bus_offs | input | 2 | Byte offset inside the 32-bit word |
| bus_size | input | 2 | Access size in bytes minus one |
| bus_wdata | input | 32 | Write value, right-justified |
| bus_rdata | output | 32 | Read value, registered |
| bus_rvalid | output | 1 | Read value valid, the cycle after a read |
| be_start | output | 1 | Pulse: command ready for the backend |
| be_cmd_len | output | AW+1 | Number of command bytes stored |
| be_cancel | output | 1 | Pulse: cancel the running command |
| be_done | input | 1 | Pulse: backend finished |
| be_selftest | input | 1 | Self-test complete, sampled with be_done |
| be_we | input | 1 | Backend byte write to the store |
| be_addr | input | AW | Backend byte address |
| be_wdata | input | 8 | Backend write byte |
| be_rdata | output | 8 | Store byte at be_addr |
| evt_cmd_ready | output | 1 | Pulse: command-ready event |
| evt_rsp_ready | output | 1 | Pulse: response-ready event |

## Verification
The main bench instance is built with a 16-byte store. This makes the full-store drop, the free-space burst count at every fill level and the boundary where the length field equals the stored count reachable in a few dozen accesses. A second instance with a 512-byte store exists only so that the burst count can exceed 255, which exercises the byte-wide saturation. The backend is modelled in the bench, so the command bytes can be read back through its port and a response of known length can be scripted.

// File: rtl/cmdfifo_pkg.sv
package cmdfifo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RX    = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } xfer_state_e;

  typedef struct packed {
    logic valid;
    logic cmdrdy;
    logic dav;
    logic expect_more;
    logic selftest;
  } flags_t;

  localparam int B_VALID    = 7;
  localparam int B_CMDRDY   = 6;
  localparam int B_GO       = 5;
  localparam int B_RETRY    = 1;
  localparam int B_CANCEL   = 24;

  localparam logic [31:0] CMD_BITS = (32'd1 << B_CMDRDY) | (32'd1 << B_GO) | (32'd1 << B_RETRY);

  // bytes actually moved by one access: requested size clipped at the word end
  function automatic logic [2:0] lane_limit(input logic [1:0] offs, input logic [1:0] size);
    logic [2:0] want;
    logic [2:0] room;
    want = {1'b0, size} + 3'd1;
    room = 3'd4 - {1'b0, offs};
    return (want < room) ? want : room;
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] size);
    case (size)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      2'd2:    return 32'h00ff_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  // place one byte of a big-endian length held in store bytes 2..5
  function automatic logic [31:0] hdr_merge(input logic [31:0] hdr, input logic [31:0] pos,
                                            input logic [7:0] b);
    logic [31:0] r;
    r = hdr;
    case (pos)
      32'd2:   r[31:24] = b;
      32'd3:   r[23:16] = b;
      32'd4:   r[15:8]  = b;
      32'd5:   r[7:0]   = b;
      default: r = hdr;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] burst_calc(input logic dav, input logic [31:0] rsp_len,
                                             input logic [31:0] r_off, input logic [31:0] depth,
                                             input logic [31:0] w_off, input logic byte_wide);
    logic [31:0] n;
    n = dav ? (rsp_len - r_off) : (depth - w_off);
    if (byte_wide && n > 32'd255) n = 32'd255;
    return n[15:0];
  endfunction

  function automatic flags_t flags_set(input logic valid, input logic cmdrdy, input logic dav,
                                       input logic expect_more, input logic keep_st);
    flags_t f;
    f.valid       = valid;
    f.cmdrdy      = cmdrdy;
    f.dav         = dav;
    f.expect_more = expect_more;
    f.selftest    = keep_st;
    return f;
  endfunction

endpackage

// File: rtl/cmdfifo_lanes.sv
module cmdfifo_lanes #(
  parameter int DEPTH = 4096,
  parameter int OFFW  = $clog2(DEPTH) + 1
) (
  input  logic [1:0]      offs,
  input  logic [1:0]      size,
  input  logic [OFFW-1:0] w_off,
  input  logic [OFFW-1:0] r_off,
  input  logic [OFFW-1:0] rsp_len,
  input  logic            dav,
  output logic [2:0]      nlanes,
  output logic [3:0]      wr_mask,
  output logic [2:0]      wr_cnt,
  output logic            wr_full,
  output logic [3:0]      rd_mask,
  output logic [2:0]      rd_cnt,
  output logic            rd_last
);
  import cmdfifo_pkg::*;

  assign nlanes = lane_limit(offs, size);

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign wr_mask[i] = (32'(nlanes) > i) && ((32'(w_off) + i) < DEPTH);
    if (i == 0) begin : g_first
      assign rd_mask[i] = dav && (nlanes != 3'd0);
    end else begin : g_rest
      assign rd_mask[i] = dav && (32'(nlanes) > i) && ((32'(r_off) + i) < 32'(rsp_len));
    end
  end

  assign wr_cnt  = 3'($countones(wr_mask));
  assign rd_cnt  = 3'($countones(rd_mask));
  assign wr_full = (32'(w_off) + 32'(nlanes)) > DEPTH;
  assign rd_last = (rd_cnt != 3'd0) && ((32'(r_off) + 32'(rd_cnt)) >= 32'(rsp_len));

endmodule

// File: rtl/cmdfifo_buf.sv
module cmdfifo_buf #(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [3:0]    wr_en,
  input  logic [AW-1:0] wr_base,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_base,
  output logic [31:0]   rd_data,
  input  logic          be_we,
  input  logic [AW-1:0] be_addr,
  input  logic [7:0]    be_wdata,
  output logic [7:0]    be_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (wr_en[i]) mem[wr_base + AW'(i)] <= wr_data[8*i +: 8];
    end
    if (be_we) mem[be_addr] <= be_wdata;
  end

  for (genvar i = 0; i < 4; i++) begin : g_rd
    assign rd_data[8*i +: 8] = mem[rd_base + AW'(i)];
  end

  assign be_rdata = mem[be_addr];

endmodule

// File: rtl/cmdfifo_ctrl.sv
module cmdfifo_ctrl #(
  parameter int         DEPTH  = 4096,
  parameter logic [1:0] FAMILY = 2'b01,
  parameter int         AW     = $clog2(DEPTH),
  parameter int         OFFW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic            bus_sel,
  input  logic [1:0]      bus_offs,
  input  logic [1:0]      bus_size,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            bus_rvalid,
  input  logic            be_done,
  input  logic            be_selftest,
  input  logic            be_we,
  input  logic [AW-1:0]   be_addr,
  input  logic [7:0]      be_wdata,
  output logic            be_start,
  output logic            be_cancel,
  output logic            evt_cmd_ready,
  output logic            evt_rsp_ready,
  input  logic [2:0]      nlanes,
  input  logic [3:0]      wr_mask,
  input  logic [2:0]      wr_cnt,
  input  logic            wr_full,
  input  logic [3:0]      rd_mask,
  input  logic [2:0]      rd_cnt,
  input  logic            rd_last,
  input  logic [31:0]     store_rd,
  output logic [3:0]      store_wr_en,
  output logic [OFFW-1:0] w_off,
  output logic [OFFW-1:0] r_off,
  output logic [OFFW-1:0] rsp_len,
  output logic            dav
);
  import cmdfifo_pkg::*;

  localparam logic [31:0] DEPTH32 = 32'(DEPTH);

  xfer_state_e     state_q, state_d;
  flags_t          flg_q, flg_d;
  logic [OFFW-1:0] w_off_q, w_off_d, r_off_q, r_off_d, rsp_len_q, rsp_len_d;
  logic [31:0]     cmd_hdr_q, cmd_hdr_d, rsp_hdr_q;
  logic            abort_q, abort_d;
  logic            start_d, cancel_d, evt_cr_d, evt_rsp_d;
  logic            start_q, cancel_q, evt_cr_q, evt_rsp_q;
  logic [31:0]     rdata_q, rdata_d;
  logic            rvalid_q;

  // named access events, used by the update logic and the assertions
  logic        acc_st_wr, acc_data_wr, acc_data_rd, done_hit, data_take;
  logic [31:0] st_val, st_cmd, status_word;
  logic [15:0] burst;
  logic [OFFW-1:0] w_new;
  logic [31:0] hdr_nx;

  assign done_hit    = be_done && (state_q == ST_EXEC);
  assign acc_st_wr   = bus_valid && bus_write && !bus_sel && !done_hit;
  assign acc_data_wr = bus_valid && bus_write &&  bus_sel && !done_hit;
  assign acc_data_rd = bus_valid && !bus_write && bus_sel;
  assign data_take   = acc_data_wr &&
                       ((state_q == ST_READY) || ((state_q == ST_RX) && flg_q.expect_more));

  assign st_val      = (bus_wdata & size_mask(bus_size)) << {bus_offs, 3'b000};
  assign st_cmd      = st_val & CMD_BITS;
  assign store_wr_en = data_take ? wr_mask : 4'b0000;
  assign w_new       = w_off_q + OFFW'(wr_cnt);

  always_comb begin
    hdr_nx = cmd_hdr_q;
    for (int i = 0; i < 4; i++) begin
      if (store_wr_en[i]) hdr_nx = hdr_merge(hdr_nx, 32'(w_off_q) + i, bus_wdata[8*i +: 8]);
    end
  end

  assign burst = burst_calc(flg_q.dav, 32'(rsp_len_q), 32'(r_off_q), DEPTH32, 32'(w_off_q),
                            bus_size == 2'd0);
  assign status_word = {4'b0000, FAMILY, 2'b00, burst, flg_q.valid, flg_q.cmdrdy, 1'b0,
                        flg_q.dav, flg_q.expect_more, flg_q.selftest, 2'b00};

  // read data path: status is a pure view, data port lanes fall back to 0xFF
  always_comb begin
    rdata_d = rdata_q;
    if (bus_valid && !bus_write) begin
      if (!bus_sel) begin
        rdata_d = (status_word >> {bus_offs, 3'b000}) & size_mask(bus_size);
      end else begin
        rdata_d = 32'h0;
        for (int i = 0; i < 4; i++) begin
          if (32'(nlanes) > i) rdata_d[8*i +: 8] = rd_mask[i] ? store_rd[8*i +: 8] : 8'hff;
        end
      end
    end
  end

  always_comb begin
    state_d   = state_q;
    flg_d     = flg_q;
    w_off_d   = w_off_q;
    r_off_d   = r_off_q;
    rsp_len_d = rsp_len_q;
    cmd_hdr_d = cmd_hdr_q;
    abort_d   = abort_q;
    start_d   = 1'b0;
    cancel_d  = 1'b0;
    evt_cr_d  = 1'b0;
    evt_rsp_d = 1'b0;
    if (done_hit) begin
      w_off_d = '0;
      r_off_d = '0;
      if (abort_q) begin
        state_d  = ST_READY;
        flg_d    = flags_set(1'b0, 1'b1, 1'b0, 1'b0, flg_q.selftest | be_selftest);
        abort_d  = 1'b0;
        evt_cr_d = 1'b1;
      end else begin
        state_d   = ST_DONE;
        flg_d     = flags_set(1'b1, 1'b0, 1'b1, 1'b0, flg_q.selftest | be_selftest);
        rsp_len_d = (rsp_hdr_q > DEPTH32) ? OFFW'(DEPTH) : rsp_hdr_q[OFFW-1:0];
        evt_rsp_d = 1'b1;
      end
    end else if (acc_st_wr) begin
      if (st_val[B_CANCEL] && state_q == ST_EXEC) cancel_d = 1'b1;
      if (st_cmd == (32'd1 << B_CMDRDY)) begin
        unique case (state_q)
          ST_IDLE: begin
            state_d  = ST_READY;
            flg_d    = flags_set(1'b0, 1'b1, 1'b0, 1'b0, flg_q.selftest);
            evt_cr_d = 1'b1;
          end
          ST_READY: begin
            w_off_d = '0;
            r_off_d = '0;
          end
          ST_RX, ST_DONE: begin
            state_d  = ST_READY;
            flg_d    = flags_set(1'b0, 1'b1, 1'b0, 1'b0, flg_q.selftest);
            w_off_d  = '0;
            r_off_d  = '0;
            evt_cr_d = 1'b1;
          end
          ST_EXEC: begin
            abort_d  = 1'b1;
            cancel_d = 1'b1;
          end
          default: state_d = state_q;
        endcase
      end else if (st_cmd == (32'd1 << B_GO)) begin
        if (state_q == ST_RX && !flg_q.expect_more) begin
          state_d = ST_EXEC;
          start_d = 1'b1;
        end
      end else if (st_cmd == (32'd1 << B_RETRY)) begin
        if (state_q == ST_DONE) begin
          r_off_d = '0;
          flg_d   = flags_set(1'b1, 1'b0, 1'b1, 1'b0, flg_q.selftest);
        end
      end
    end else if (data_take) begin
      if (state_q == ST_READY) state_d = ST_RX;
      w_off_d   = w_new;
      cmd_hdr_d = hdr_nx;
      if (wr_full) begin
        flg_d = flags_set(1'b1, 1'b0, 1'b0, 1'b0, flg_q.selftest);
      end else if (32'(w_new) > 32'd5) begin
        flg_d = flags_set(1'b1, 1'b0, 1'b0, hdr_nx > 32'(w_new), flg_q.selftest);
      end else begin
        flg_d = flags_set(1'b1, 1'b0, 1'b0, 1'b1, flg_q.selftest);
      end
    end else if (acc_data_rd && state_q == ST_DONE) begin
      r_off_d = r_off_q + OFFW'(rd_cnt);
      if (rd_last) flg_d = flags_set(1'b1, 1'b0, 1'b0, 1'b0, flg_q.selftest);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      flg_q     <= '0;
      w_off_q   <= '0;
      r_off_q   <= '0;
      rsp_len_q <= '0;
      cmd_hdr_q <= '0;
      rsp_hdr_q <= '0;
      abort_q   <= 1'b0;
      start_q   <= 1'b0;
      cancel_q  <= 1'b0;
      evt_cr_q  <= 1'b0;
      evt_rsp_q <= 1'b0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      flg_q     <= flg_d;
      w_off_q   <= w_off_d;
      r_off_q   <= r_off_d;
      rsp_len_q <= rsp_len_d;
      cmd_hdr_q <= cmd_hdr_d;
      abort_q   <= abort_d;
      start_q   <= start_d;
      cancel_q  <= cancel_d;
      evt_cr_q  <= evt_cr_d;
      evt_rsp_q <= evt_rsp_d;
      rdata_q   <= rdata_d;
      rvalid_q  <= bus_valid && !bus_write;
      if (be_we) rsp_hdr_q <= hdr_merge(rsp_hdr_q, 32'(be_addr), be_wdata);
    end
  end

  assign bus_rdata     = rdata_q;
  assign bus_rvalid    = rvalid_q;
  assign be_start      = start_q;
  assign be_cancel     = cancel_q;
  assign evt_cmd_ready = evt_cr_q;
  assign evt_rsp_ready = evt_rsp_q;
  assign w_off         = w_off_q;
  assign r_off         = r_off_q;
  assign rsp_len       = rsp_len_q;
  assign dav           = flg_q.dav;

  AST_EXPECT_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q.expect_more |-> state_q == ST_RX); // R4
  AST_DAV_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q.dav |-> state_q == ST_DONE); // R7
  AST_START_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> state_q == ST_EXEC && !flg_q.expect_more); // R6
  AST_WOFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(w_off_q) <= DEPTH32); // R14
  AST_RSP_EVT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rsp_q |-> flg_q.valid && flg_q.dav && r_off_q == '0); // R7
  AST_CR_EVT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cr_q |-> state_q == ST_READY && flg_q.cmdrdy && w_off_q == '0); // R2
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> w_off_q == '0 && !flg_q.valid); // R3

endmodule

// File: rtl/cmdfifo_engine.sv
module cmdfifo_engine #(
  parameter int         DEPTH  = 4096,
  parameter logic [1:0] FAMILY = 2'b01,
  localparam int        AW     = $clog2(DEPTH),
  localparam int        OFFW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic            bus_sel,
  input  logic [1:0]      bus_offs,
  input  logic [1:0]      bus_size,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            bus_rvalid,
  output logic            be_start,
  output logic [OFFW-1:0] be_cmd_len,
  output logic            be_cancel,
  input  logic            be_done,
  input  logic            be_selftest,
  input  logic            be_we,
  input  logic [AW-1:0]   be_addr,
  input  logic [7:0]      be_wdata,
  output logic [7:0]      be_rdata,
  output logic            evt_cmd_ready,
  output logic            evt_rsp_ready
);
  logic [2:0]      nlanes, wr_cnt, rd_cnt;
  logic [3:0]      wr_mask, rd_mask, store_wr_en;
  logic            wr_full, rd_last, dav;
  logic [OFFW-1:0] w_off, r_off, rsp_len;
  logic [31:0]     store_rd;

  cmdfifo_lanes #(.DEPTH(DEPTH), .OFFW(OFFW)) u_lanes (
    .offs(bus_offs), .size(bus_size), .w_off(w_off), .r_off(r_off), .rsp_len(rsp_len),
    .dav(dav), .nlanes(nlanes), .wr_mask(wr_mask), .wr_cnt(wr_cnt), .wr_full(wr_full),
    .rd_mask(rd_mask), .rd_cnt(rd_cnt), .rd_last(rd_last)
  );

  cmdfifo_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .wr_en(store_wr_en), .wr_base(w_off[AW-1:0]), .wr_data(bus_wdata),
    .rd_base(r_off[AW-1:0]), .rd_data(store_rd), .be_we(be_we), .be_addr(be_addr),
    .be_wdata(be_wdata), .be_rdata(be_rdata)
  );

  cmdfifo_ctrl #(.DEPTH(DEPTH), .FAMILY(FAMILY), .AW(AW), .OFFW(OFFW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_sel(bus_sel), .bus_offs(bus_offs), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .be_done(be_done),
    .be_selftest(be_selftest), .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_start(be_start), .be_cancel(be_cancel), .evt_cmd_ready(evt_cmd_ready),
    .evt_rsp_ready(evt_rsp_ready), .nlanes(nlanes), .wr_mask(wr_mask), .wr_cnt(wr_cnt),
    .wr_full(wr_full), .rd_mask(rd_mask), .rd_cnt(rd_cnt), .rd_last(rd_last),
    .store_rd(store_rd), .store_wr_en(store_wr_en), .w_off(w_off), .r_off(r_off),
    .rsp_len(rsp_len), .dav(dav)
  );

  assign be_cmd_len = w_off;

endmodule

// File: tb/cmdfifo_engine_tb.sv
module cmdfifo_engine_tb;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_sel = 1'b0;
  logic [1:0] bus_offs = '0, bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic be_done = 1'b0, be_selftest = 1'b0, be_we = 1'b0;
  logic [3:0] be_addr = '0;
  logic [7:0] be_wdata = '0;

  logic [31:0] bus_rdata, bus_rdata2;
  logic bus_rvalid, bus_rvalid2, be_start, be_start2, be_cancel, be_cancel2;
  logic [4:0] be_cmd_len;
  logic [9:0] be_cmd_len2;
  logic [7:0] be_rdata, be_rdata2;
  logic evt_cr, evt_rsp, evt_cr2, evt_rsp2;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cmdfifo_engine #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel(bus_sel),
    .bus_offs(bus_offs), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .be_start(be_start), .be_cmd_len(be_cmd_len),
    .be_cancel(be_cancel), .be_done(be_done), .be_selftest(be_selftest), .be_we(be_we),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_rdata(be_rdata),
    .evt_cmd_ready(evt_cr), .evt_rsp_ready(evt_rsp)
  );

  cmdfifo_engine #(.DEPTH(512)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel(bus_sel),
    .bus_offs(bus_offs), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata2),
    .bus_rvalid(bus_rvalid2), .be_start(be_start2), .be_cmd_len(be_cmd_len2),
    .be_cancel(be_cancel2), .be_done(be_done), .be_selftest(be_selftest), .be_we(be_we),
    .be_addr({5'd0, be_addr}), .be_wdata(be_wdata), .be_rdata(be_rdata2),
    .evt_cmd_ready(evt_cr2), .evt_rsp_ready(evt_rsp2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic sel, input logic [1:0] offs,
                     input logic [1:0] size, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_sel = sel;
    bus_offs = offs; bus_size = size; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd = bus_rdata;
  endtask

  // status word as the requirements define it: family 01 at 27:26
  function automatic logic [31:0] sts(input int burst, input logic [7:0] flags);
    return 32'h0400_0000 | (32'(burst) << 8) | 32'(flags);
  endfunction

  task automatic rd_sts(input string req, input int burst, input logic [7:0] flags);
    logic [31:0] v;
    acc(1'b0, 1'b0, 2'd0, 2'd3, 32'h0, v);
    check(req, v, sts(burst, flags));
  endtask

  task automatic be_put(input int a, input logic [7:0] d);
    @(negedge clk);
    be_we = 1'b1; be_addr = 4'(a); be_wdata = d;
  endtask

  task automatic be_finish(input logic st);
    @(negedge clk);
    be_we = 1'b0; be_done = 1'b1; be_selftest = st;
    @(negedge clk);
    be_done = 1'b0; be_selftest = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [7:0] cmd [10];
    logic [7:0] rsp [8];
    cmd = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0a, 8'h06, 8'h07, 8'h08, 8'h09};
    rsp = '{8'hc4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'haa, 8'hbb};
    do_reset();

    // R9: saturation on the 512-byte instance, before any traffic
    acc(1'b0, 1'b0, 2'd1, 2'd0, 32'h0, v);
    check("R9 byte-wide burst saturates", bus_rdata2, 32'h0000_00ff);
    acc(1'b0, 1'b0, 2'd0, 2'd3, 32'h0, v);
    check("R9 word burst 512", bus_rdata2, 32'h0402_0000);

    rd_sts("R1 reset status", D, 8'h00);
    acc(1'b0, 1'b1, 2'd0, 2'd3, 32'h0, v);
    check("R8 data read idle", v, 32'hffff_ffff);
    acc(1'b1, 1'b1, 2'd0, 2'd3, 32'h1234_5678, v);
    rd_sts("R3 data write idle dropped", D, 8'h00);
    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h20, v);
    check("R6 go idle no start", 32'(be_start), 32'd0);
    rd_sts("R6 go idle ignored", D, 8'h00);

    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h40, v);
    check("R2 cmd-ready event", 32'(evt_cr), 32'd1);
    rd_sts("R2 ready status", D, 8'h40);

    acc(1'b1, 1'b1, 2'd0, 2'd0, 32'h80, v);
    rd_sts("R4 first byte enters reception", D - 1, 8'h88);
    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h20, v);
    check("R6 go with expect set no start", 32'(be_start), 32'd0);
    acc(1'b1, 1'b1, 2'd0, 2'd3, 32'h0000_0001, v);
    rd_sts("R9 free space after 5 bytes", D - 5, 8'h88);
    acc(1'b1, 1'b1, 2'd2, 2'd3, 32'h0000_060a, v);
    rd_sts("R11 clipped write, R5 length not reached", D - 7, 8'h88);
    acc(1'b1, 1'b1, 2'd1, 2'd2, 32'h0009_0807, v);
    rd_sts("R5 length reached clears expect", D - 10, 8'h80);

    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h20, v);
    check("R6 start pulse", 32'(be_start), 32'd1);
    check("R6 command length", 32'(be_cmd_len), 32'd10);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      be_addr = 4'(i);
      #1;
      check("R11 command byte order", 32'(be_rdata), 32'(cmd[i]));
    end
    acc(1'b1, 1'b1, 2'd0, 2'd3, 32'hdead_beef, v);
    rd_sts("R3 data write executing dropped", D - 10, 8'h80);
    acc(1'b0, 1'b1, 2'd0, 2'd3, 32'h0, v);
    check("R8 data read executing", v, 32'hffff_ffff);

    for (int i = 0; i < 8; i++) be_put(i, rsp[i]);
    be_finish(1'b1);
    check("R7 response event", 32'(evt_rsp), 32'd1);
    rd_sts("R7 complete flags with self-test", 8, 8'h94);
    acc(1'b1, 1'b1, 2'd0, 2'd0, 32'h55, v);
    rd_sts("R3 data write complete dropped", 8, 8'h94);

    acc(1'b0, 1'b1, 2'd0, 2'd3, 32'h0, v);
    check("R7 first response word", v, 32'h0000_00c4);
    rd_sts("R9 remaining response bytes", 4, 8'h94);
    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h02, v);
    rd_sts("R10 retry rewinds", 8, 8'h94);
    acc(1'b0, 1'b1, 2'd0, 2'd3, 32'h0, v);
    check("R10 reread first word", v, 32'h0000_00c4);
    acc(1'b0, 1'b1, 2'd3, 2'd3, 32'h0, v);
    check("R11 clipped read one byte", v, 32'h0000_0000);
    rd_sts("R11 clipped read consumed one", 3, 8'h94);
    acc(1'b0, 1'b1, 2'd0, 2'd3, 32'h0, v);
    check("R7 last bytes then 0xFF", v, 32'hffbb_aa08);
    rd_sts("R7 last byte leaves valid", D, 8'h84);
    acc(1'b0, 1'b1, 2'd0, 2'd1, 32'h0, v);
    check("R8 read after drain", v, 32'h0000_ffff);

    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h40, v);
    check("R12 cmd-ready event", 32'(evt_cr), 32'd1);
    rd_sts("R12 back to ready", D, 8'h44);

    acc(1'b1, 1'b1, 2'd0, 2'd0, 32'h00, v);
    rd_sts("R4 reception with self-test kept", D - 1, 8'h8c);
    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h40, v);
    check("R13 abort in reception event", 32'(evt_cr), 32'd1);
    rd_sts("R13 abort in reception status", D, 8'h44);

    acc(1'b1, 1'b1, 2'd0, 2'd3, 32'h0, v);
    acc(1'b1, 1'b1, 2'd0, 2'd1, 32'h0000_0600, v);
    rd_sts("R5 six-byte command complete", D - 6, 8'h84);
    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h20, v);
    check("R6 second start", 32'(be_cmd_len), 32'd6);
    acc(1'b1, 1'b0, 2'd0, 2'd3, 32'h0100_0000, v);
    check("R13 cancel bit pulse", 32'(be_cancel), 32'd1);
    acc(1'b1, 1'b0, 2'd0, 2'd0, 32'h40, v);
    check("R13 abort in execution cancels", 32'(be_cancel), 32'd1);
    rd_sts("R13 still executing", D - 6, 8'h84);
    be_finish(1'b0);
    check("R13 abort completes with event", 32'(evt_cr), 32'd1);
    check("R13 no response event", 32'(evt_rsp), 32'd0);
    rd_sts("R13 ready after abort", D, 8'h44);

    acc(1'b1, 1'b1, 2'd0, 2'd3, 32'hffff_0000, v);
    acc(1'b1, 1'b1, 2'd0, 2'd3, 32'h0000_ffff, v);
    acc(1'b1, 1'b1, 2'd0, 2'd3, 32'h0, v);
    acc(1'b1, 1'b1, 2'd0, 2'd3, 32'h0, v);
    rd_sts("R14 store full still expecting", 0, 8'h8c);
    acc(1'b1, 1'b1, 2'd0, 2'd0, 32'h77, v);
    rd_sts("R14 overflow leaves valid only", 0, 8'h84);

    do_reset();
    rd_sts("R1 reset clears self-test", D, 8'h00);

    finish_run();
  end
endmodule